// File: doc/BRIEF.md
# Serial Configuration Memory Sequencer

This block models the read-out logic of a serial bit-stream store that an FPGA reads while it configures itself. A small internal bit array is filled from parameters when the block is built. An address counter walks through that array, one bit for each rising edge of the configuration clock. The bit at the current address is presented on a data output, and that output has a separate output-enable signal in place of a real tri-state pin. The FPGA's own configuration pins drive the block directly, so no separate controller is needed to sequence the read-out.

Two inputs control the block. The combined reset/output-enable input has overriding priority: while it is high, the counter returns to zero and the data line is released. The active-low chip enable lets the counter run and lets the data line be driven. When the last stored bit has been shifted out, the block releases the data line and pulls its cascade enable-out low. The next device in a daisy chain can then take over the shared line without contention. The counter then stays parked and does not wrap until it is reset again.

Top module: `cfgmem_seq`

## Requirements
- R1: While `rst_oe` is high, `data_oe` is low in the same cycle whatever `ce_n` is. At the next rising edge of `clk`, the counter returns to address 0 and the exhausted state is cleared, so `ceo_n` reads high after that edge.
- R2: While `rst_oe` is low and `ce_n` is high, `data_oe` is low and the counter holds its address. When `ce_n` returns low, the stream continues from the bit where it stopped.
- R3: While `rst_oe` and `ce_n` are both low and the stream is not exhausted, `data_oe` is high and `data_o` carries the bit at the current address. Each rising edge of `clk` advances the address by one.
- R4: After DEPTH enabled edges since the last reset, all bits have been shifted out. From then on `ceo_n` is low and `data_oe` is low.
- R5: Once exhausted, the block stays exhausted and the counter does not wrap, however many further enabled clock edges arrive, until `rst_oe` or `rst` is asserted.
- R6: The synchronous power-on reset `rst` clears the counter and the exhausted state. The first enabled cycle after it presents the bit at address 0, with `ceo_n` high.
- R7: The stored bit at address a equals the XOR of all bits of (a AND PAT_MASK), XORed with PAT_INV. With the default parameters (DEPTH 1024, PAT_MASK 0x2D5, PAT_INV 1), this is the bit the line carries at that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Configuration clock; the address advances on its rising edge |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_oe | input | 1 | Combined reset/output enable, active high reset, overriding priority |
| ce_n | input | 1 | Active-low chip enable |
| data_o | output | 1 | Serial data value, 0 when not enabled |
| data_oe | output | 1 | High when `data_o` drives the shared line |
| ceo_n | output | 1 | Cascade enable-out, low once the stream is exhausted |

## Verification
The read-out is driven with one uninterrupted stream from address 0 to beyond the end. This separates correct bit order, the exact point where the stream becomes exhausted, and any wrap of the counter. A second stream has chip-enable gaps in it, to show whether a gap loses or repeats a bit. A third pulses reset/output-enable while chip enable is active and while the stream is exhausted, to show that the reset has priority. Random mixes of the two control inputs, with rare resets, check every cycle against a bench-side model of address and exhaustion. This finds off-by-one errors in hold and advance that directed runs might miss.

// File: rtl/cfgmem_pkg.sv
package cfgmem_pkg;

    // Decoded control intent for one clock cycle
    typedef struct packed {
        logic clear;   // return counter to origin
        logic run;     // counter may advance, line may be driven
    } cfg_ctrl_t;

    // Read-out phase derived from control and counter state
    typedef enum logic [1:0] {
        PH_CLEAR  = 2'd0,
        PH_PAUSED = 2'd1,
        PH_STREAM = 2'd2,
        PH_SPENT  = 2'd3
    } cfg_phase_e;

    // Stored bit for an address: parity of masked address, optionally inverted
    function automatic logic pattern_bit(input logic [31:0] addr,
                                         input logic [31:0] mask,
                                         input logic        inv);
        return (^(addr & mask)) ^ inv;
    endfunction

endpackage

// File: rtl/cfgmem_pin_decode.sv
module cfgmem_pin_decode
    import cfgmem_pkg::*;
(
    input  logic      rst_oe,
    input  logic      ce_n,
    output cfg_ctrl_t ctrl
);
    // reset/output-enable overrides chip enable
    always_comb begin
        ctrl.clear = rst_oe;
        ctrl.run   = !rst_oe && !ce_n;
    end
endmodule

// File: rtl/cfgmem_bitstore.sv
module cfgmem_bitstore
    import cfgmem_pkg::*;
#(
    parameter int          DEPTH    = 1024,
    parameter logic [31:0] PAT_MASK = 32'h2D5,
    parameter logic        PAT_INV  = 1'b1,
    localparam int         AW       = $clog2(DEPTH)
) (
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);
    logic [DEPTH-1:0] mem;

    // Array contents fixed at elaboration from the pattern parameters
    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        assign mem[i] = pattern_bit(32'(i), PAT_MASK, PAT_INV);
    end

    assign rd_bit = mem[rd_addr];
endmodule

// File: rtl/cfgmem_addr_ctr.sv
module cfgmem_addr_ctr
    import cfgmem_pkg::*;
#(
    parameter int  DEPTH = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  cfg_ctrl_t     ctrl,
    output logic [AW-1:0] addr,
    output logic          spent
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    always_ff @(posedge clk) begin
        if (rst || ctrl.clear) begin
            addr  <= '0;
            spent <= 1'b0;
        end else if (ctrl.run && !spent) begin
            if (addr == LAST) spent <= 1'b1;
            else              addr  <= addr + 1'b1;
        end
    end

    assert_clear_R1: assert property (@(posedge clk) disable iff (rst)
        ctrl.clear |=> (addr == '0) && !spent);

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.clear && !ctrl.run) |=> $stable(addr) && $stable(spent));

    assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && !spent && addr != LAST) |=> addr == AW'($past(addr) + 1'b1));

    assert_no_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (spent && !ctrl.clear) |=> spent && addr == LAST);

    assert_reach_end_R4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && !spent && addr == LAST) |=> spent);
endmodule

// File: rtl/cfgmem_seq.sv
module cfgmem_seq
    import cfgmem_pkg::*;
#(
    parameter int          DEPTH    = 1024,
    parameter logic [31:0] PAT_MASK = 32'h2D5,
    parameter logic        PAT_INV  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_oe,
    input  logic ce_n,
    output logic data_o,
    output logic data_oe,
    output logic ceo_n
);
    localparam int AW = $clog2(DEPTH);

    cfg_ctrl_t   ctrl;
    logic [AW-1:0] addr;
    logic          spent;
    logic          rd_bit;
    cfg_phase_e    phase;

    cfgmem_pin_decode u_dec (
        .rst_oe (rst_oe),
        .ce_n   (ce_n),
        .ctrl   (ctrl)
    );

    cfgmem_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk   (clk),
        .rst   (rst),
        .ctrl  (ctrl),
        .addr  (addr),
        .spent (spent)
    );

    cfgmem_bitstore #(
        .DEPTH    (DEPTH),
        .PAT_MASK (PAT_MASK),
        .PAT_INV  (PAT_INV)
    ) u_store (
        .rd_addr (addr),
        .rd_bit  (rd_bit)
    );

    always_comb begin
        if (ctrl.clear)     phase = PH_CLEAR;
        else if (spent)     phase = PH_SPENT;
        else if (ctrl.run)  phase = PH_STREAM;
        else                phase = PH_PAUSED;
    end

    assign data_oe = (phase == PH_STREAM);
    assign data_o  = data_oe & rd_bit;
    assign ceo_n   = !spent;

    // A device that has handed over never drives the shared line
    assert_handover_R4: assert property (@(posedge clk) disable iff (rst)
        !ceo_n |-> !data_oe);

    // reset/output-enable releases the line regardless of chip enable
    assert_release_R1: assert property (@(posedge clk) disable iff (rst)
        rst_oe |-> !data_oe);
endmodule

// File: tb/cfgmem_seq_bench.sv
`timescale 1ns/1ps
module cfgmem_seq_bench;
    localparam int DEPTH = 1024;
    localparam int MASK  = 'h2D5;
    localparam bit INV   = 1'b1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rst_oe = 1'b1;
    logic ce_n = 1'b1;
    logic data_o, data_oe, ceo_n;
    wire  line = data_oe ? data_o : 1'bz;

    int checks = 0;
    int fails  = 0;
    int m_addr = 0;
    bit m_done = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cfgmem_seq u_cfgmem_seq (
        .clk(clk), .rst(rst), .rst_oe(rst_oe), .ce_n(ce_n),
        .data_o(data_o), .data_oe(data_oe), .ceo_n(ceo_n)
    );

    function automatic logic want_bit(int a);
        int m;
        logic p;
        m = a & MASK;
        p = INV;
        for (int k = 0; k < 32; k++) p ^= m[k];
        return p;
    endfunction

    task automatic check(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b (addr %0d) at %0t", req, act, exp, m_addr, $time);
        end
    endtask

    // One cycle: drive after falling edge, check, then update model at rising edge
    task automatic step(bit r, bit oe, bit ce, string tag = "");
        @(negedge clk);
        rst = r; rst_oe = oe; ce_n = ce;
        #1;
        if (!r) begin
            logic exp_oe;
            exp_oe = !oe && !ce && !m_done;
            if (oe)        check("R1", data_oe, 1'b0);
            else if (ce)   check("R2", data_oe, 1'b0);
            else if (m_done) check(tag == "" ? "R4" : tag, data_oe, 1'b0);
            else           check("R3", data_oe, 1'b1);
            check(tag == "" ? "R4" : tag, ceo_n, !m_done);
            if (exp_oe) check("R7", line, want_bit(m_addr));
            else        check("R1", line, 1'bz);
        end
        @(posedge clk);
        if (r || oe) begin m_addr = 0; m_done = 0; end
        else if (!ce && !m_done) begin
            if (m_addr == DEPTH - 1) m_done = 1;
            else m_addr++;
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 17;
        void'($urandom(seed));
        // power-on reset
        step(1, 0, 0);
        step(1, 0, 0);
        // R6: first enabled cycle presents address 0
        step(0, 0, 0, "R6");
        // full uninterrupted stream past the end (R4, R5)
        for (int i = 0; i < DEPTH + 40; i++) step(0, 0, 0, i >= DEPTH ? "R5" : "");
        check("R5", ceo_n, 1'b0);
        // rst_oe while exhausted and chip enable active: R1
        step(0, 1, 0);
        step(0, 0, 1);
        check("R1", ceo_n, 1'b1);
        // stream with chip-enable gaps: R2
        for (int i = 0; i < 200; i++) step(0, 0, (i % 7) > 4);
        // rst_oe pulse mid-stream with chip enable low
        step(0, 1, 0);
        step(0, 0, 0, "R6");
        // power-on reset mid-stream: R6
        for (int i = 0; i < 30; i++) step(0, 0, 0);
        step(1, 0, 0);
        step(0, 0, 0, "R6");
        // constrained random mixes
        for (int seg = 0; seg < 6; seg++) begin
            int rprob = (seg % 3 == 0) ? 0 : 3;
            int cprob = 5 + seg * 8;
            for (int i = 0; i < 1500; i++) begin
                bit oe = ($urandom_range(999) < rprob);
                bit ce = ($urandom_range(99) < cprob);
                step(0, oe, ce);
            end
        end
        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule